// File: doc/BRIEF.md
# Seat Belt Alarm Controller

This controller watches the ignition key and the driver's seat belt. When the key goes on, it starts a seconds timer and gives the driver a grace period to buckle up. If the belt is still open when that period runs out, it raises the alarm. The alarm lasts for a second, bounded period. It stops earlier if the belt is fastened or the key is turned off.

The block has three states: idle, grace and sounding. One saturating seconds counter serves both the grace period and the alarm period. The counter advances only on a one-cycle seconds strobe from the system. A latched completion flag stops the alarm from arming a second time within one key cycle. The flag is set when the belt is fastened or when the alarm ends with the key still on. Both outputs come straight from registers. The alarm level is a pure function of the current state.

Top module: `belt_alarm_ctrl`

## Requirements
- R1: Asynchronous active-low reset puts the block in idle, with `alarmOn` and `timerStart` both 0. This holds even when reset arrives while the alarm is sounding.
- R2: In idle, `keyOn` high at a clock edge makes `timerStart` 1 for exactly the following cycle. It is not repeated while the key stays on.
- R3: Key off during the grace state returns to idle. The next key-on gives a fresh `timerStart` pulse.
- R4: The seconds counter restarts from zero on key-on. Strobes seen while the key is off do not advance it. With the belt open, `alarmOn` rises one cycle after the counter reaches `GRACE_SEC` strobes.
- R5: The alarm holds until the counter reaches `GRACE_SEC + ALARM_SEC` strobes since key-on. It falls in the cycle after that.
- R6: Belt fastened while sounding ends the alarm in the next cycle.
- R7: Key off while sounding ends the alarm in the next cycle and returns to idle.
- R8: Belt fastened during grace keeps the alarm off for the rest of the key cycle. The belt wins over a grace timeout in the same cycle.
- R9: Once the alarm has ended with the key still on, `alarmOn` stays 0 until the key goes off and on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyOn | input | 1 | Ignition key level, 1 = on |
| beltOn | input | 1 | Seat belt level, 1 = fastened |
| secTick | input | 1 | One-cycle strobe, once per second |
| alarmOn | output | 1 | Alarm level, registered |
| timerStart | output | 1 | One-cycle pulse when the grace timer starts |

## Verification
A wrong state or a wrong completion flag shows at the ports as a missing or extra `timerStart` pulse. It can also show as an `alarmOn` edge one strobe early or late, or as an alarm that re-arms inside one key cycle. Every such fault appears one clock after the edge that caused it, because both outputs are registered straight off the next state. Counter faults show at the strobe count where the alarm rises or falls. The stimulus therefore counts strobes exactly across every boundary.

// File: rtl/belt_alarm_pkg.sv
package belt_alarm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRACE = 2'd1,
    ST_SOUND = 2'd2
  } alarmState_t;

  typedef struct packed {
    logic clear;
    logic run;
  } timerCtl_t;
endpackage

// File: rtl/belt_alarm_timer.sv
module belt_alarm_timer
  import belt_alarm_pkg::*;
#(
  parameter int GRACE_SEC = 5,
  parameter int ALARM_SEC = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      secTick,
  input  timerCtl_t ctl,
  output logic      graceUp,
  output logic      alarmUp
);
  localparam int LIMIT = GRACE_SEC + ALARM_SEC;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] GRACE_V = CW'(GRACE_SEC);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] secCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCount <= '0;
    end else if (ctl.clear) begin
      secCount <= '0;
    end else if (ctl.run && secTick && (secCount != LIMIT_V)) begin
      secCount <= secCount + 1'b1;
    end
  end

  assign graceUp = (secCount >= GRACE_V);
  assign alarmUp = (secCount == LIMIT_V);
endmodule

// File: rtl/belt_alarm_fsm.sv
module belt_alarm_fsm
  import belt_alarm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      keyOn,
  input  logic      beltOn,
  input  logic      graceUp,
  input  logic      alarmUp,
  output timerCtl_t ctl,
  output logic      alarmOn,
  output logic      timerStart
);
  alarmState_t state, stateNext;
  logic doneLatch, doneNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (keyOn) stateNext = ST_GRACE;
      ST_GRACE: begin
        if (!keyOn)                               stateNext = ST_IDLE;
        else if (!doneLatch && !beltOn && graceUp) stateNext = ST_SOUND;
      end
      ST_SOUND: begin
        if (!keyOn)                 stateNext = ST_IDLE;
        else if (beltOn || alarmUp) stateNext = ST_GRACE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    doneNext = doneLatch;
    if (!keyOn || state == ST_IDLE)                          doneNext = 1'b0;
    else if (state == ST_GRACE && beltOn)                    doneNext = 1'b1;
    else if (state == ST_SOUND && (beltOn || alarmUp))       doneNext = 1'b1;
  end

  always_comb begin
    ctl.clear = (stateNext == ST_GRACE) && (state != ST_GRACE);
    ctl.run   = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      doneLatch  <= 1'b0;
      alarmOn    <= 1'b0;
      timerStart <= 1'b0;
    end else begin
      state      <= stateNext;
      doneLatch  <= doneNext;
      alarmOn    <= (stateNext == ST_SOUND);
      timerStart <= (state == ST_IDLE) && keyOn;
    end
  end
endmodule

// File: rtl/belt_alarm_ctrl.sv
module belt_alarm_ctrl
  import belt_alarm_pkg::*;
#(
  parameter int GRACE_SEC = 5,
  parameter int ALARM_SEC = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyOn,
  input  logic beltOn,
  input  logic secTick,
  output logic alarmOn,
  output logic timerStart
);
  timerCtl_t timerCtl;
  logic graceUp, alarmUp;

  belt_alarm_fsm u_fsm (
    .clk(clk), .rstN(rstN), .keyOn(keyOn), .beltOn(beltOn),
    .graceUp(graceUp), .alarmUp(alarmUp), .ctl(timerCtl),
    .alarmOn(alarmOn), .timerStart(timerStart)
  );

  belt_alarm_timer #(.GRACE_SEC(GRACE_SEC), .ALARM_SEC(ALARM_SEC)) u_timer (
    .clk(clk), .rstN(rstN), .secTick(secTick), .ctl(timerCtl),
    .graceUp(graceUp), .alarmUp(alarmUp)
  );
endmodule

// File: rtl/belt_alarm_chk.sv
module belt_alarm_chk (
  input logic clk,
  input logic rstN,
  input logic keyOn,
  input logic beltOn,
  input logic graceUp,
  input logic doneLatch,
  input logic alarmOn,
  input logic timerStart
);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |=> !timerStart);

  assert_start_from_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |-> $past(keyOn));

  assert_alarm_after_grace_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmOn) |-> $past(graceUp));

  assert_belt_ends_alarm_R6: assert property (@(posedge clk) disable iff (!rstN)
    (alarmOn && beltOn) |=> !alarmOn);

  assert_key_off_silences_R7: assert property (@(posedge clk) disable iff (!rstN)
    !keyOn |=> (!alarmOn && !timerStart));

  assert_done_stays_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneLatch && keyOn) |=> !alarmOn);
endmodule

bind belt_alarm_fsm belt_alarm_chk u_chk (
  .clk(clk), .rstN(rstN), .keyOn(keyOn), .beltOn(beltOn),
  .graceUp(graceUp), .doneLatch(doneLatch),
  .alarmOn(alarmOn), .timerStart(timerStart)
);

// File: tb/belt_alarm_ctrl_test.sv
module belt_alarm_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyOn = 1'b0, beltOn = 1'b0, secTick = 1'b0;
  logic alarmOn, timerStart;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  belt_alarm_ctrl uut (
    .clk(clk), .rstN(rstN), .keyOn(keyOn), .beltOn(beltOn),
    .secTick(secTick), .alarmOn(alarmOn), .timerStart(timerStart)
  );

  // {keyOn, beltOn, secTick, expected alarmOn, expected timerStart}, per cycle
  localparam int NV = 43;
  localparam logic [4:0] VEC [NV] = '{
    5'b10001, 5'b10100, 5'b10100, 5'b10100, 5'b10100, 5'b10100,
    5'b10010, 5'b10110, 5'b10110, 5'b10110, 5'b10110, 5'b10110,
    5'b10000, 5'b10100, 5'b00000, 5'b10001, 5'b11100,
    5'b10100, 5'b10100, 5'b10100, 5'b10100, 5'b10100, 5'b10100,
    5'b00000, 5'b10001, 5'b10100, 5'b10100, 5'b10100, 5'b10100,
    5'b10100, 5'b10010, 5'b11000, 5'b10100, 5'b00000, 5'b10001,
    5'b10100, 5'b10100, 5'b10100, 5'b10100, 5'b10100, 5'b10010,
    5'b00000, 5'b00000
  };

  function automatic string rowTag(int i);
    if (i == 0 || i == 15 || i == 24 || i == 34 || i == 42) return "R2";
    if (i == 14 || i == 23 || i == 33) return "R3";
    if (i <= 6 || (i >= 25 && i <= 30) || (i >= 35 && i <= 40)) return "R4";
    if (i <= 12) return "R5";
    if (i >= 16 && i <= 22) return "R8";
    if (i == 31) return "R6";
    if (i == 41) return "R7";
    return "R9";
  endfunction

  task automatic check(string tag, logic expA, logic expS);
    checks++;
    if (alarmOn !== expA || timerStart !== expS) begin
      errors++;
      $display("FAIL %s alarmOn=%b timerStart=%b expected alarmOn=%b timerStart=%b",
               tag, alarmOn, timerStart, expA, expS);
    end
  endtask

  task automatic step(logic k, logic b, logic t);
    keyOn = k; beltOn = b; secTick = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      check(rowTag(i), VEC[i][1], VEC[i][0]);
    end

    // R4: strobes while key off do not count toward the grace period
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 1'b1);
      check("R4", 1'b0, 1'b0);
    end
    step(1'b1, 1'b0, 1'b0);
    check("R2", 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    check("R4", 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    check("R4", 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R4", 1'b1, 1'b0);

    // R8: belt fastened exactly at grace timeout wins
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    check("R8", 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 1'b1);
      check("R8", 1'b0, 1'b0);
    end

    // R1: reset while sounding
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    check("R4", 1'b1, 1'b0);
    rstN = 1'b0;
    #1;
    check("R1", 1'b0, 1'b0);
    @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rstN = 1'b1;
    step(1'b1, 1'b0, 1'b0);
    check("R1", 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule